// File: doc/BRIEF.md
# Staged Datapoint Waveform Sequencer

This block plays a stored waveform out to a converter. It reads groups of datapoint words from a wide waveform memory, with one group per memory access. Each group is parked in a staging register and then moved into a shift register. From there one word at a time goes to the converter output register, at a word rate equal to the fundamental clock divided by an integer k. The memory is read once for every group of words, so it can be much slower than the word rate. The next group is requested as soon as the staging register has been emptied.

Playback follows a nested schedule. Each segment descriptor gives a start address, a group count and a repeat count. The segments are played in index order, and the whole list is played a programmed number of cycles. The block starts in one of three ways. In free-running mode it loops forever. In gated mode it plays once and advances only while a gate input is high. In triggered mode it plays once for each trigger edge. Once configured and enabled, it needs no further control.

Top module: `wave_sequencer`

## Requirements
- R1: After reset, busy, done, underrun, dacStrobe and memReq are all low.
- R2: Word 0 of a group sits in bits [WORD_W-1:0] of memData and is played first, followed by the next higher words. While memory keeps up and nothing stalls, consecutive dacStrobe pulses are exactly k clocks apart. A clkDiv value of 0 behaves as k = 1.
- R3: Groups are fetched from start+g for g = 0..groups-1, and this run is repeated reps times per segment. Segments go in index order, and the whole list is repeated cycleReps times. A count of 0 behaves as 1. The bench model returns word w of address a as {a, w} (address in the upper 8 bits, word index in the lower 4).
- R4: memReq is high only while the block is busy, the staging register is empty and fetches remain. While memReq is high and memValid is low, memAddr holds steady. Each memValid pulse taken with memReq loads exactly one group.
- R5: Mode values 2 and 3 are triggered mode. A rising trigger while enable is high and the block is idle starts one full sequence. Triggers during playback are ignored. At the end of the sequence busy falls and done rises.
- R6: Mode value 1 is gated mode. The block starts when enabled and not done, and words advance only on clocks where gate is high. The word divider is frozen while gate is low.
- R7: Mode value 0 is free-running mode. The sequence repeats without a gap and done never rises. The mode must stay steady during a run.
- R8: underrun is set if, after the first word of a run, a word is due, the shift register is empty and the next group has not yet arrived while fetches remain. The output then holds its last word. underrun stays set until the next start.
- R9: With enable low, the block is idle on the next clock: busy is low, memReq is low and done is cleared.
- R10: mode is a 2-bit code: 0 is free-running, 1 is gated, 2 is triggered, and 3 behaves as triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fundamental clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Arms the block; low aborts and idles |
| mode | input | 2 | Start mode code (R10) |
| gate | input | 1 | Advance qualifier in gated mode |
| trigger | input | 1 | Start request in triggered mode (rising edge) |
| clkDiv | input | DIV_W | Word-rate divider k |
| segStart | input | NSEG*ADDR_W | Start address per segment |
| segGroups | input | NSEG*CNT_W | Group count per segment |
| segReps | input | NSEG*CNT_W | Repeat count per segment |
| cycleReps | input | CNT_W | Cycles of the whole segment list |
| memReq | output | 1 | Group fetch request |
| memAddr | output | ADDR_W | Address of the requested group |
| memValid | input | 1 | Group data valid, taken while memReq is high |
| memData | input | GROUP_WORDS*WORD_W | Fetched group of words |
| dacData | output | WORD_W | Converter output word |
| dacStrobe | output | 1 | One-clock pulse when dacData takes a new word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| underrun | output | 1 | Sticky starvation flag |

## Verification
Assertions check the following on every clock:
- the fetch address stays steady while a request waits;
- done and busy are never high together;
- no word is emitted after a gate-low clock;
- free-running mode never raises done;
- the underrun flag stays set;
- disabling the block idles it at once.

Only the bench scenarios can show the data itself: the exact word order across the nested repeat counts, the k-clock word spacing including the seamless wrap in free-running mode, the treatment of zero counts, and the fact that an ignored trigger adds no extra words. They also show that a slow memory raises underrun while the words still come out in the right order, and that the flag clears on the next run.

// File: rtl/wsq_pkg.sv
`timescale 1ns/1ps
package wsq_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_GATED = 2'd1,
    MODE_TRIG  = 2'd2,
    MODE_TRIG2 = 2'd3
  } wsqMode_e;

  typedef struct packed {
    logic clear;
    logic accept;
    logic advance;
  } wsqStrobe_t;
endpackage

// File: rtl/wsq_datapath.sv
`timescale 1ns/1ps
module wsq_datapath
  import wsq_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int GROUP_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wsqStrobe_t                    strb,
  input  logic [GROUP_WORDS*WORD_W-1:0] memData,
  output logic                          shEmpty,
  output logic                          stgValid,
  output logic [WORD_W-1:0]             dacData,
  output logic                          dacStrobe
);
  localparam int GRP_W = GROUP_WORDS * WORD_W;
  localparam int SC_W  = $clog2(GROUP_WORDS + 1);

  logic [GRP_W-1:0] stgData;
  logic [GRP_W-1:0] shReg;
  logic [SC_W-1:0]  shCnt;

  assign shEmpty = (shCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgData   <= '0;
      stgValid  <= 1'b0;
      shReg     <= '0;
      shCnt     <= '0;
      dacData   <= '0;
      dacStrobe <= 1'b0;
    end else begin
      dacStrobe <= 1'b0;
      if (strb.clear) begin
        stgValid <= 1'b0;
        shCnt    <= '0;
      end else begin
        if (strb.accept) begin
          stgData  <= memData;
          stgValid <= 1'b1;
        end
        if (strb.advance) begin
          if (!shEmpty) begin
            dacData   <= shReg[WORD_W-1:0];
            shReg     <= shReg >> WORD_W;
            shCnt     <= shCnt - SC_W'(1);
            dacStrobe <= 1'b1;
          end else if (stgValid) begin
            dacData   <= stgData[WORD_W-1:0];
            shReg     <= stgData >> WORD_W;
            shCnt     <= SC_W'(GROUP_WORDS - 1);
            stgValid  <= 1'b0;
            dacStrobe <= 1'b1;
          end
        end
      end
    end
  end

  AST_STAGE_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear && shEmpty && stgValid) |=> (!stgValid && dacStrobe)); // R2
endmodule

// File: rtl/wsq_ctrl.sv
`timescale 1ns/1ps
module wsq_ctrl
  import wsq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int NSEG   = 2,
  parameter int DIV_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [1:0]             mode,
  input  logic                   gate,
  input  logic                   trigger,
  input  logic [DIV_W-1:0]       clkDiv,
  input  logic [NSEG*ADDR_W-1:0] segStart,
  input  logic [NSEG*CNT_W-1:0]  segGroups,
  input  logic [NSEG*CNT_W-1:0]  segReps,
  input  logic [CNT_W-1:0]       cycleReps,
  input  logic                   memValid,
  input  logic                   shEmpty,
  input  logic                   stgValid,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   busy,
  output logic                   done,
  output logic                   underrun,
  output wsqStrobe_t             strb
);
  localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1;

  function automatic logic [CNT_W-1:0] cntEff(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  logic [ADDR_W-1:0] startArr [NSEG];
  logic [CNT_W-1:0]  grpArr   [NSEG];
  logic [CNT_W-1:0]  repArr   [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign startArr[i] = segStart[i*ADDR_W +: ADDR_W];
    assign grpArr[i]   = segGroups[i*CNT_W +: CNT_W];
    assign repArr[i]   = segReps[i*CNT_W +: CNT_W];
  end

  logic [SEG_W-1:0] segIdx;
  logic [CNT_W-1:0] grpIdx, repIdx, cycIdx;
  logic             fetchDone, primed, trigPrev;
  logic [DIV_W-1:0] divCnt, kEff;
  logic             isFree, isGated, isTrig, gateOk, start, advance, accept;
  logic             divHit, lastGrp, lastRep, lastSeg, lastCyc, seqEnd, starve;

  assign isFree  = (mode == MODE_FREE);
  assign isGated = (mode == MODE_GATED);
  assign isTrig  = mode[1];
  assign kEff    = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
  assign gateOk  = !isGated || gate;
  assign divHit  = (divCnt >= kEff - DIV_W'(1));
  assign start   = enable && !busy && (isTrig ? (trigger && !trigPrev) : !done);
  assign advance = busy && gateOk && divHit;
  assign memReq  = busy && !stgValid && !fetchDone;
  assign accept  = memReq && memValid;
  assign memAddr = startArr[segIdx] + ADDR_W'(grpIdx);

  assign lastGrp = (grpIdx == cntEff(grpArr[segIdx]) - CNT_W'(1));
  assign lastRep = (repIdx == cntEff(repArr[segIdx]) - CNT_W'(1));
  assign lastSeg = (segIdx == SEG_W'(NSEG - 1));
  assign lastCyc = (cycIdx == cntEff(cycleReps) - CNT_W'(1));

  assign seqEnd = advance && shEmpty && !stgValid && fetchDone;
  assign starve = advance && shEmpty && !stgValid && !fetchDone && primed;

  assign strb.clear   = start || !enable;
  assign strb.accept  = accept;
  assign strb.advance = advance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segIdx <= '0; grpIdx <= '0; repIdx <= '0; cycIdx <= '0;
      fetchDone <= 1'b0; divCnt <= '0; primed <= 1'b0; trigPrev <= 1'b0;
      busy <= 1'b0; done <= 1'b0; underrun <= 1'b0;
    end else begin
      trigPrev <= trigger;
      if (strb.clear) begin
        segIdx <= '0; grpIdx <= '0; repIdx <= '0; cycIdx <= '0;
        fetchDone <= 1'b0; divCnt <= '0; primed <= 1'b0;
      end else begin
        if (accept) begin
          if (!lastGrp) grpIdx <= grpIdx + CNT_W'(1);
          else begin
            grpIdx <= '0;
            if (!lastRep) repIdx <= repIdx + CNT_W'(1);
            else begin
              repIdx <= '0;
              if (!lastSeg) segIdx <= segIdx + SEG_W'(1);
              else begin
                segIdx <= '0;
                if (!lastCyc) cycIdx <= cycIdx + CNT_W'(1);
                else begin
                  cycIdx <= '0;
                  if (!isFree) fetchDone <= 1'b1;
                end
              end
            end
          end
        end
        if (busy && gateOk) divCnt <= divHit ? '0 : divCnt + DIV_W'(1);
        if (advance && shEmpty && stgValid) primed <= 1'b1;
      end

      if (!enable)     busy <= 1'b0;
      else if (start)  busy <= 1'b1;
      else if (seqEnd) busy <= 1'b0;

      if (!enable || start) done <= 1'b0;
      else if (seqEnd)      done <= 1'b1;

      if (start)       underrun <= 1'b0;
      else if (starve) underrun <= 1'b1;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid && enable) |=> (memReq && $stable(memAddr))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R5
  AST_FREE_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isFree) |=> !done); // R7
  AST_UNDERRUN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !start) |=> underrun); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busy && !memReq && !done)); // R9
endmodule

// File: rtl/wave_sequencer.sv
`timescale 1ns/1ps
module wave_sequencer
  import wsq_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int GROUP_WORDS = 4,
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 4,
  parameter int NSEG        = 2,
  parameter int DIV_W       = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic [1:0]                    mode,
  input  logic                          gate,
  input  logic                          trigger,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic [NSEG*ADDR_W-1:0]        segStart,
  input  logic [NSEG*CNT_W-1:0]         segGroups,
  input  logic [NSEG*CNT_W-1:0]         segReps,
  input  logic [CNT_W-1:0]              cycleReps,
  output logic                          memReq,
  output logic [ADDR_W-1:0]             memAddr,
  input  logic                          memValid,
  input  logic [GROUP_WORDS*WORD_W-1:0] memData,
  output logic [WORD_W-1:0]             dacData,
  output logic                          dacStrobe,
  output logic                          busy,
  output logic                          done,
  output logic                          underrun
);
  wsqStrobe_t strb;
  logic       shEmpty, stgValid;

  wsq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NSEG(NSEG), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .gate(gate),
    .trigger(trigger), .clkDiv(clkDiv), .segStart(segStart), .segGroups(segGroups),
    .segReps(segReps), .cycleReps(cycleReps), .memValid(memValid),
    .shEmpty(shEmpty), .stgValid(stgValid), .memReq(memReq), .memAddr(memAddr),
    .busy(busy), .done(done), .underrun(underrun), .strb(strb)
  );

  wsq_datapath #(.WORD_W(WORD_W), .GROUP_WORDS(GROUP_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData),
    .shEmpty(shEmpty), .stgValid(stgValid), .dacData(dacData), .dacStrobe(dacStrobe)
  );

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mode == MODE_GATED && !gate) |=> !dacStrobe); // R6
endmodule

// File: tb/wave_sequencer_bench.sv
`timescale 1ns/1ps
module wave_sequencer_bench;
  localparam int WORD_W = 12, GROUP_WORDS = 4, ADDR_W = 8, CNT_W = 4, NSEG = 2, DIV_W = 8;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, gate = 1'b0, trigger = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [DIV_W-1:0] clkDiv = 8'd1;
  logic [NSEG*ADDR_W-1:0] segStart = '0;
  logic [NSEG*CNT_W-1:0] segGroups = '0, segReps = '0;
  logic [CNT_W-1:0] cycleReps = '0;
  logic memReq, memValid = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [GROUP_WORDS*WORD_W-1:0] memData = '0;
  logic [WORD_W-1:0] dacData, expW;
  logic dacStrobe, busy, done, underrun;

  always #2 clk = ~clk;

  wave_sequencer u_wave_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .gate(gate), .trigger(trigger),
    .clkDiv(clkDiv), .segStart(segStart), .segGroups(segGroups), .segReps(segReps),
    .cycleReps(cycleReps), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .dacData(dacData), .dacStrobe(dacStrobe), .busy(busy),
    .done(done), .underrun(underrun)
  );

  int vectors = 0, errors = 0;
  logic [WORD_W-1:0] expQ[$];
  int memLat = 0, latCnt = 0, fetchCnt = 0, strobeCnt = 0, gateViol = 0;
  int cyc = 0, lastCyc = 0, kExp = 1;
  bit lastValid = 0, chkSpacing = 0, gatePrev = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // driver: expected words from the R3 schedule and the R2 word order
  task automatic pushSeq(input int loops);
    for (int l = 0; l < loops; l++)
      for (int c = 0; c < eff(int'(cycleReps)); c++)
        for (int s = 0; s < NSEG; s++)
          for (int r = 0; r < eff(int'(segReps[s*CNT_W +: CNT_W])); r++)
            for (int g = 0; g < eff(int'(segGroups[s*CNT_W +: CNT_W])); g++)
              for (int w = 0; w < GROUP_WORDS; w++)
                expQ.push_back({ADDR_W'(int'(segStart[s*ADDR_W +: ADDR_W]) + g), 4'(w)});
  endtask

  // memory model: word w of address a is {a, w}
  always @(negedge clk) begin
    if (memValid) memValid = 1'b0;
    else if (memReq) begin
      if (latCnt >= memLat) begin
        for (int w = 0; w < GROUP_WORDS; w++) memData[w*WORD_W +: WORD_W] = {memAddr, 4'(w)};
        memValid = 1'b1;
        latCnt = 0;
        fetchCnt++;
      end else latCnt++;
    end else latCnt = 0;
  end

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    cyc++;
    if (dacStrobe) begin
      strobeCnt++;
      if (mode == 2'd1 && !gatePrev) gateViol++;
      if (chkSpacing && lastValid) check(cyc - lastCyc == kExp, "R2 word spacing", cyc - lastCyc, kExp);
      lastValid = 1; lastCyc = cyc;
      if (expQ.size() > 0) begin
        expW = expQ.pop_front();
        check(dacData == expW, "R2/R3 word value", int'(dacData), int'(expW));
      end
    end
    gatePrev = gate;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseTrig();
    trigger = 1'b1; tick(1); trigger = 1'b0; tick(1);
  endtask

  task automatic waitDone(input int lim);
    int n = 0;
    while (!done && n < lim) begin tick(1); n++; end
  endtask

  task automatic waitDrain(input int lim);
    int n = 0;
    while (expQ.size() > 0 && n < lim) begin tick(1); n++; end
  endtask

  task automatic cfgA();
    segStart = {8'h40, 8'h10}; segGroups = {4'd1, 4'd2}; segReps = {4'd3, 4'd2}; cycleReps = 4'd2;
  endtask

  task automatic cfgB();
    segStart = {8'h20, 8'h80}; segGroups = {4'd3, 4'd0}; segReps = {4'd0, 4'd0}; cycleReps = 4'd0;
  endtask

  task automatic newScene(input logic [1:0] m, input int k);
    enable = 1'b0; tick(2);
    mode = m; clkDiv = DIV_W'(k); kExp = eff(k);
    lastValid = 0; fetchCnt = 0; strobeCnt = 0; gateViol = 0;
  endtask

  int sc;
  initial begin
    tick(3);
    check(!busy && !done && !underrun && !memReq && !dacStrobe, "R1 reset idle",
          {busy, done, underrun, memReq, dacStrobe}, 0);
    rstN = 1'b1; tick(2);
    check(!busy && !memReq, "R1 idle after reset", {busy, memReq}, 0);

    // triggered, k = 3, config A
    cfgA(); newScene(2'd2, 3); chkSpacing = 1; memLat = 0;
    enable = 1'b1; tick(10);
    check(!busy, "R10 no start without trigger", busy, 0);
    pushSeq(1);
    pulseTrig(); tick(20); pulseTrig();
    waitDone(2000);
    check(done && !busy, "R5 done at end", {done, busy}, 2);
    check(expQ.size() == 0, "R3 all words seen", expQ.size(), 0);
    check(fetchCnt == 14, "R4 one fetch per group", fetchCnt, 14);
    sc = strobeCnt; tick(40);
    check(strobeCnt == sc && strobeCnt == 56, "R5 ignored trigger adds nothing", strobeCnt, 56);

    // code 3 as triggered, clkDiv 0 as k=1, zero counts as one
    cfgB(); newScene(2'd3, 0);
    enable = 1'b1; tick(10);
    check(!busy, "R10 code 3 waits for trigger", busy, 0);
    pushSeq(1); pulseTrig();
    waitDone(2000);
    check(done && expQ.size() == 0 && strobeCnt == 16, "R3 zero counts as one", strobeCnt, 16);

    // gated, k = 2
    cfgA(); newScene(2'd1, 2); chkSpacing = 0; gate = 1'b0;
    pushSeq(1);
    enable = 1'b1; tick(20);
    check(strobeCnt == 0, "R6 no words with gate low", strobeCnt, 0);
    for (int i = 0; i < 200 && !done; i++) begin
      gate = 1'b1; tick(7); gate = 1'b0; tick(5);
    end
    gate = 1'b1; waitDone(500);
    check(done && expQ.size() == 0, "R6 gated sequence completes", expQ.size(), 0);
    check(gateViol == 0, "R6 word after gate low", gateViol, 0);

    // free-running, k = 1, seamless wrap
    cfgB(); newScene(2'd0, 1); chkSpacing = 1;
    pushSeq(3);
    enable = 1'b1; waitDrain(3000);
    check(expQ.size() == 0, "R7 three loops in order", expQ.size(), 0);
    check(busy && !done, "R7 still running, no done", {busy, done}, 2);
    enable = 1'b0; tick(1);
    check(!busy && !memReq && !done, "R9 disable idles", {busy, memReq, done}, 0);

    // underrun with slow memory
    cfgA(); newScene(2'd2, 1); chkSpacing = 0; memLat = 6;
    enable = 1'b1; pushSeq(1); pulseTrig();
    waitDone(5000);
    check(underrun == 1'b1, "R8 underrun set", underrun, 1);
    check(expQ.size() == 0, "R8 words still in order", expQ.size(), 0);
    tick(5);
    check(underrun == 1'b1, "R8 underrun sticky", underrun, 1);
    memLat = 0; pushSeq(1); pulseTrig();
    check(underrun == 1'b0, "R8 cleared on start", underrun, 0);
    waitDone(2000);
    check(done && !underrun && expQ.size() == 0, "R8 clean run", underrun, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule